// File: doc/BRIEF.md
# Masked Vector Register ALU

This block is a compact integer vector execution unit. It holds a file of vector registers, a vector-length register and a per-element mask register. It executes one instruction at a time, walking the elements in order at one element per clock. An instruction combines two source vectors element by element, or combines one source vector with a scalar captured at issue. A compare instruction writes one mask bit per element instead of a register.

Only elements with an index below the current vector length are touched. When an arithmetic instruction carries the masked flag, an element is written only where the mask from an earlier compare holds a 1. Vector data is placed into the registers through a single-element write port and read back through a single-element read port, both used while the unit is idle.

The control is a three-state machine. IDLE accepts a new instruction and reports ready. RUN processes one element per cycle. DONE raises the completion pulse for one cycle. The transitions are: IDLE to RUN on an accepted instruction with a vector length of at least 1; IDLE to DONE on an accepted instruction with a vector length of 0; RUN to DONE after the last element; DONE to IDLE unconditionally.

Top module: `vmask_alu`

## Requirements
- R1: After reset `ready` is 1, `done` is 0, `vl_out` is 64 and `mask_out` is all zeros.
- R2: A cycle with `vl_we` high loads the length register from `vl_din`. Any value above 64 is stored as 64. An instruction accepted in that same cycle runs with the length held before the write.
- R3: Opcodes 0, 1 and 2 compute Vd[i] = Vj[i] + Vk[i], Vj[i] - Vk[i] and the low 64 bits of Vj[i] * Vk[i], all modulo 2^64, for every i below the length.
- R4: Opcodes 3, 4 and 5 perform the same add, subtract and multiply with the scalar operand in place of Vk[i]. The scalar is the value on `in_scalar` in the accept cycle.
- R5: Opcode 6 (equal) and opcode 7 (unsigned less-than of Vj[i] against Vk[i]) set mask bit i to the predicate for i below the length. They clear every mask bit at or above the length, leave all vector registers unchanged, and ignore `in_masked`.
- R6: With `in_masked` set, an arithmetic instruction writes element i only where mask bit i is 1. Elements at or above the length are never written.
- R7: With issue at edge 0, element i is written at edge i+1. `done` is high for exactly one cycle, the cycle following edge L, where L is the length (edge 0 itself when L is 0).
- R8: `ready` is low from the accept edge until `done` falls. An `in_valid` seen while `ready` is low is ignored.
- R9: The element write port (`wr_en`, `wr_reg`, `wr_elem`, `wr_data`) stores one element at a clock edge while `ready` is high, and is ignored while it is low. `rd_data` shows element `rd_elem` of register `rd_reg` combinationally.
- R10: `mask_out` changes only through compare instructions. Arithmetic instructions and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered this cycle |
| in_op | input | 3 | Opcode (0-7, see R3-R5) |
| in_masked | input | 1 | Write only where the mask bit is 1 |
| in_vd | input | 3 | Destination register |
| in_vj | input | 3 | First source register |
| in_vk | input | 3 | Second source register |
| in_scalar | input | 64 | Scalar operand for opcodes 3-5 |
| vl_we | input | 1 | Load the length register |
| vl_din | input | 7 | New length value |
| wr_en | input | 1 | Element write strobe |
| wr_reg | input | 3 | Element write register |
| wr_elem | input | 6 | Element write index |
| wr_data | input | 64 | Element write data |
| rd_reg | input | 3 | Read register |
| rd_elem | input | 6 | Read element index |
| rd_data | output | 64 | Read data |
| ready | output | 1 | Unit idle, instruction may be offered |
| done | output | 1 | One-cycle completion pulse |
| vl_out | output | 7 | Current length register |
| mask_out | output | 64 | Current mask register |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a length-register write and an instruction issue. The bench drives `vl_we` and `in_valid` at the same clock edge, then judges the outcome in two ways. The element updates must stop at the old length, and `vl_out` must show the new value afterwards.

The second pair is a running instruction and a new offer. While an instruction is in RUN, the bench drives both `in_valid` and an element write onto the destination register. The judgement is that the busy cycle-by-cycle `ready`/`done` timeline is unchanged and that the written register and mask match a model that discarded both offers.

// File: rtl/vmask_alu_pkg.sv
package vmask_alu_pkg;

    typedef enum logic [2:0] {
        OP_VADD = 3'd0,
        OP_VSUB = 3'd1,
        OP_VMUL = 3'd2,
        OP_SADD = 3'd3,
        OP_SSUB = 3'd4,
        OP_SMUL = 3'd5,
        OP_CEQ  = 3'd6,
        OP_CLTU = 3'd7
    } vop_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } vstate_e;

endpackage

// File: rtl/vreg_file.sv
module vreg_file #(
    parameter int NREGS = 8,
    parameter int NELEM = 64,
    parameter int EW    = 64
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(NREGS)-1:0] wreg,
    input  logic [$clog2(NELEM)-1:0] widx,
    input  logic [EW-1:0]            wdata,
    input  logic [$clog2(NREGS)-1:0] ra_reg,
    input  logic [$clog2(NELEM)-1:0] ra_idx,
    output logic [EW-1:0]            ra_data,
    input  logic [$clog2(NREGS)-1:0] rb_reg,
    input  logic [$clog2(NELEM)-1:0] rb_idx,
    output logic [EW-1:0]            rb_data,
    input  logic [$clog2(NREGS)-1:0] rc_reg,
    input  logic [$clog2(NELEM)-1:0] rc_idx,
    output logic [EW-1:0]            rc_data
);
    localparam int RW    = $clog2(NREGS);
    localparam int IW    = $clog2(NELEM);
    localparam int DEPTH = 2 ** (RW + IW);

    logic [EW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[{wreg, widx}] <= wdata;
        end
    end

    assign ra_data = mem[{ra_reg, ra_idx}];
    assign rb_data = mem[{rb_reg, rb_idx}];
    assign rc_data = mem[{rc_reg, rc_idx}];

endmodule

// File: rtl/velem_alu.sv
module velem_alu
    import vmask_alu_pkg::*;
#(
    parameter int EW = 64
) (
    input  vop_e          op,
    input  logic [EW-1:0] a,
    input  logic [EW-1:0] b,
    output logic [EW-1:0] res,
    output logic          pred
);
    always_comb begin
        res  = '0;
        pred = 1'b0;
        unique case (op)
            OP_VADD, OP_SADD: res = a + b;
            OP_VSUB, OP_SSUB: res = a - b;
            OP_VMUL, OP_SMUL: res = a * b;
            OP_CEQ:           pred = (a == b);
            OP_CLTU:          pred = (a < b);
        endcase
    end

endmodule

// File: rtl/vmask_alu.sv
module vmask_alu
    import vmask_alu_pkg::*;
#(
    parameter int NREGS = 8,
    parameter int NELEM = 64,
    parameter int EW    = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [2:0]                    in_op,
    input  logic                          in_masked,
    input  logic [$clog2(NREGS)-1:0]      in_vd,
    input  logic [$clog2(NREGS)-1:0]      in_vj,
    input  logic [$clog2(NREGS)-1:0]      in_vk,
    input  logic [EW-1:0]                 in_scalar,
    input  logic                          vl_we,
    input  logic [$clog2(NELEM+1)-1:0]    vl_din,
    input  logic                          wr_en,
    input  logic [$clog2(NREGS)-1:0]      wr_reg,
    input  logic [$clog2(NELEM)-1:0]      wr_elem,
    input  logic [EW-1:0]                 wr_data,
    input  logic [$clog2(NREGS)-1:0]      rd_reg,
    input  logic [$clog2(NELEM)-1:0]      rd_elem,
    output logic [EW-1:0]                 rd_data,
    output logic                          ready,
    output logic                          done,
    output logic [$clog2(NELEM+1)-1:0]    vl_out,
    output logic [NELEM-1:0]              mask_out
);
    localparam int RW = $clog2(NREGS);
    localparam int IW = $clog2(NELEM);
    localparam int LW = $clog2(NELEM + 1);

    vstate_e        state_q, state_d;
    vop_e           op_q;
    logic           masked_q;
    logic [RW-1:0]  vd_q, vj_q, vk_q;
    logic [EW-1:0]  scal_q;
    logic [LW-1:0]  len_q, vl_q;
    logic [IW-1:0]  cnt_q;
    logic [NELEM-1:0] mask_q;

    logic           issue, is_cmp, is_scal, last_elem;
    logic [EW-1:0]  vj_data, vk_data, opnd_b, alu_res;
    logic           alu_pred;
    logic           rf_we;
    logic [RW-1:0]  rf_wreg;
    logic [IW-1:0]  rf_widx;
    logic [EW-1:0]  rf_wdata;

    assign issue     = in_valid && (state_q == ST_IDLE);
    assign is_cmp    = (op_q == OP_CEQ) || (op_q == OP_CLTU);
    assign is_scal   = (op_q == OP_SADD) || (op_q == OP_SSUB) || (op_q == OP_SMUL);
    assign last_elem = (LW'(cnt_q) + LW'(1)) == len_q;
    assign opnd_b    = is_scal ? scal_q : vk_data;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (issue) state_d = (vl_q == '0) ? ST_DONE : ST_RUN;
            ST_RUN:  if (last_elem) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and register-file write selection
    always_comb begin
        ready    = (state_q == ST_IDLE);
        done     = (state_q == ST_DONE);
        rf_we    = 1'b0;
        rf_wreg  = wr_reg;
        rf_widx  = wr_elem;
        rf_wdata = wr_data;
        if (state_q == ST_RUN) begin
            if (!is_cmp && (!masked_q || mask_q[cnt_q])) begin
                rf_we    = 1'b1;
                rf_wreg  = vd_q;
                rf_widx  = cnt_q;
                rf_wdata = alu_res;
            end
        end else if (state_q == ST_IDLE && wr_en) begin
            rf_we = 1'b1;
        end
    end

    // instruction capture, element counter, length and mask registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_VADD;
            masked_q <= 1'b0;
            vd_q     <= '0;
            vj_q     <= '0;
            vk_q     <= '0;
            scal_q   <= '0;
            len_q    <= '0;
            cnt_q    <= '0;
            vl_q     <= LW'(NELEM);
            mask_q   <= '0;
        end else begin
            if (vl_we) begin
                vl_q <= (vl_din > LW'(NELEM)) ? LW'(NELEM) : vl_din;
            end
            if (issue) begin
                op_q     <= vop_e'(in_op);
                masked_q <= in_masked;
                vd_q     <= in_vd;
                vj_q     <= in_vj;
                vk_q     <= in_vk;
                scal_q   <= in_scalar;
                len_q    <= vl_q;
                cnt_q    <= '0;
                if (in_op[2:1] == 2'b11) mask_q <= '0;
            end else if (state_q == ST_RUN) begin
                cnt_q <= cnt_q + IW'(1);
                if (is_cmp) mask_q[cnt_q] <= alu_pred;
            end
        end
    end

    vreg_file #(.NREGS(NREGS), .NELEM(NELEM), .EW(EW)) u_rf (
        .clk     (clk),
        .we      (rf_we),
        .wreg    (rf_wreg),
        .widx    (rf_widx),
        .wdata   (rf_wdata),
        .ra_reg  (vj_q),
        .ra_idx  (cnt_q),
        .ra_data (vj_data),
        .rb_reg  (vk_q),
        .rb_idx  (cnt_q),
        .rb_data (vk_data),
        .rc_reg  (rd_reg),
        .rc_idx  (rd_elem),
        .rc_data (rd_data)
    );

    velem_alu #(.EW(EW)) u_alu (
        .op   (op_q),
        .a    (vj_data),
        .b    (opnd_b),
        .res  (alu_res),
        .pred (alu_pred)
    );

    assign vl_out   = vl_q;
    assign mask_out = mask_q;

endmodule

// File: rtl/vmask_alu_chk.sv
module vmask_alu_chk #(
    parameter int NELEM = 64,
    parameter int LW    = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [2:0]       in_op,
    input logic             ready,
    input logic             done,
    input logic [LW-1:0]    vl_out,
    input logic [NELEM-1:0] mask_out
);
    // R7: completion pulse lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: unit is ready again right after the pulse
    a_r7_done_to_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ready);

    // R8: accepting an instruction makes the unit busy
    a_r8_issue_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ready) |=> !ready);

    // R8: never ready while completing
    a_r8_done_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ready);

    // R2: length register never exceeds the element count
    a_r2_vl_limit: assert property (@(posedge clk) disable iff (!rst_n)
        vl_out <= LW'(NELEM));

    // R5: a compare issued with zero length leaves an empty mask
    a_r5_zero_len_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ready && in_op[2:1] == 2'b11 && vl_out == '0) |=> (mask_out == '0));

    // R10: mask holds while idle with nothing offered
    a_r10_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !in_valid) |=> $stable(mask_out));

endmodule

bind vmask_alu vmask_alu_chk #(.NELEM(NELEM), .LW(LW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_op    (in_op),
    .ready    (ready),
    .done     (done),
    .vl_out   (vl_out),
    .mask_out (mask_out)
);

// File: tb/sim_vmask_alu.sv
module sim_vmask_alu;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic        in_masked = 1'b0;
    logic [2:0]  in_vd = '0, in_vj = '0, in_vk = '0;
    logic [63:0] in_scalar = '0;
    logic        vl_we = 1'b0;
    logic [6:0]  vl_din = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_reg = '0;
    logic [5:0]  wr_elem = '0;
    logic [63:0] wr_data = '0;
    logic [2:0]  rd_reg = '0;
    logic [5:0]  rd_elem = '0;
    logic [63:0] rd_data;
    logic        ready, done;
    logic [6:0]  vl_out;
    logic [63:0] mask_out;

    vmask_alu u0 (.*);

    always #(CLK_P/2) clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    logic [63:0] mr [8][64];
    logic [63:0] mmask = '0;
    int          mvl = 64;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] fval(input int r, input int e);
        int rr;
        rr = (r == 1 && (e % 3) == 0) ? 0 : r;
        return 64'h9E3779B97F4A7C15 * 64'(rr * 64 + e + 1) + 64'(e);
    endfunction

    function automatic logic [63:0] calc(input int op, input logic [63:0] a, input logic [63:0] b);
        case (op % 3)
            0: return a + b;
            1: return a - b;
            default: return a * b;
        endcase
    endfunction

    task automatic set_vl(input int v);
        @(negedge clk);
        vl_we = 1'b1; vl_din = 7'(v);
        @(negedge clk);
        vl_we = 1'b0;
        mvl = (v > 64) ? 64 : v;
        chk(vl_out == 7'(mvl), "R2 vl write/clamp", 64'(vl_out), 64'(mvl));
    endtask

    task automatic verify_reg(input int r, input string tag);
        for (int e = 0; e < 64; e++) begin
            rd_reg = 3'(r); rd_elem = 6'(e);
            #1;
            chk(rd_data == mr[r][e], tag, rd_data, mr[r][e]);
        end
        chk(mask_out == mmask, "R10 mask contents", mask_out, mmask);
    endtask

    task automatic run_op(input int op, input bit msk, input int vd, input int vj, input int vk,
                          input logic [63:0] s, input bit poke, input int vl_also, input string tag);
        int len;
        logic [63:0] nv [64];
        logic [63:0] nm;
        len = mvl;
        nm = mmask;
        for (int i = 0; i < 64; i++) nv[i] = mr[vd][i];
        if (op >= 6) nm = '0;
        for (int i = 0; i < len; i++) begin
            logic [63:0] a, b;
            a = mr[vj][i];
            b = (op >= 3 && op <= 5) ? s : mr[vk][i];
            if (op == 6) nm[i] = (a == b);
            else if (op == 7) nm[i] = (a < b);
            else if (!msk || mmask[i]) nv[i] = calc(op, a, b);
        end
        @(negedge clk);
        in_valid = 1'b1; in_op = 3'(op); in_masked = msk;
        in_vd = 3'(vd); in_vj = 3'(vj); in_vk = 3'(vk); in_scalar = s;
        if (vl_also >= 0) begin vl_we = 1'b1; vl_din = 7'(vl_also); end
        @(negedge clk);
        in_valid = 1'b0; vl_we = 1'b0; in_scalar = ~s;
        if (vl_also >= 0) mvl = (vl_also > 64) ? 64 : vl_also;
        for (int k = 0; k <= len + 1; k++) begin
            chk(done == (k == len), "R7 done timing", 64'(done), 64'(k == len));
            chk(ready == (k > len), "R8 ready timing", 64'(ready), 64'(k > len));
            if (poke && k == 1) begin
                in_valid = 1'b1; in_op = 3'd6; in_vj = 3'(vj); in_vk = 3'(vj);
                wr_en = 1'b1; wr_reg = 3'(vd); wr_elem = 6'd0; wr_data = 64'hDEAD_BEEF_0000_0001;
            end
            if (poke && k == 2) begin
                in_valid = 1'b0; wr_en = 1'b0;
            end
            if (k <= len) @(negedge clk);
        end
        for (int i = 0; i < 64; i++) mr[vd][i] = nv[i];
        mmask = nm;
        verify_reg(vd, tag);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ready == 1'b1, "R1 ready after reset", 64'(ready), 64'd1);
        chk(done == 1'b0, "R1 done after reset", 64'(done), 64'd0);
        chk(vl_out == 7'd64, "R1 vl after reset", 64'(vl_out), 64'd64);
        chk(mask_out == '0, "R1 mask after reset", mask_out, 64'd0);

        // R9 load all registers through the element write port
        for (int r = 0; r < 8; r++) begin
            for (int e = 0; e < 64; e++) begin
                wr_en = 1'b1; wr_reg = 3'(r); wr_elem = 6'(e); wr_data = fval(r, e);
                mr[r][e] = fval(r, e);
                @(negedge clk);
            end
        end
        wr_en = 1'b0;
        verify_reg(3, "R9 element write/read");

        // R3 vector-vector
        run_op(0, 0, 4, 0, 1, '0, 0, -1, "R3 vadd");
        set_vl(10);
        run_op(1, 0, 5, 0, 1, '0, 0, -1, "R3 vsub partial length");
        set_vl(100);
        run_op(2, 0, 6, 2, 3, '0, 0, -1, "R3 vmul");

        // R4 vector-scalar
        run_op(3, 0, 7, 2, 0, 64'h0123_4567_89AB_CDEF, 0, -1, "R4 sadd");
        run_op(4, 0, 7, 3, 0, 64'hFFFF_0000_FFFF_0000, 0, -1, "R4 ssub");
        run_op(5, 0, 3, 3, 0, 64'd7, 0, -1, "R4 smul in place");

        // R5/R6 compare then masked arithmetic
        run_op(6, 0, 2, 0, 1, '0, 0, -1, "R5 cmp eq");
        run_op(0, 1, 4, 2, 3, '0, 0, -1, "R6 masked vadd");
        set_vl(20);
        run_op(7, 1, 2, 2, 3, '0, 0, -1, "R5 cmp ltu masked flag ignored");
        run_op(5, 1, 5, 0, 0, 64'd3, 0, -1, "R6 masked smul");

        // R7 zero and unit lengths
        set_vl(0);
        run_op(7, 0, 1, 2, 3, '0, 0, -1, "R5 zero-length compare");
        run_op(0, 0, 6, 0, 1, '0, 0, -1, "R7 zero-length vadd");
        set_vl(1);
        run_op(1, 0, 6, 0, 1, '0, 0, -1, "R7 single element");

        // R8/R9 offers while busy
        set_vl(30);
        run_op(0, 0, 6, 0, 0, '0, 1, -1, "R8 busy offer ignored");

        // R2 length write in the issue cycle
        set_vl(16);
        run_op(2, 0, 7, 0, 1, '0, 0, 40, "R2 same-cycle length write");
        chk(vl_out == 7'd40, "R2 new length visible", 64'(vl_out), 64'd40);

        // R10 idle cycles keep the mask
        repeat (3) @(negedge clk);
        chk(mask_out == mmask, "R10 mask idle hold", mask_out, mmask);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule